// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is a tag-only directory for a set-associative cache. It decides whether each address lookup hits or misses and keeps running counts of lookups and misses, so that a miss rate can be worked out. It stores no data. Each lookup gives a registered result one cycle later: a hit flag, the way that was hit or filled, and the requester's core identifier passed through unchanged.

Cache capacity, block size and associativity are parameters. Together they fix the number of sets and how an address splits into its fields. On a miss, the block fills the lowest-numbered empty way in the set. When the set is full, a victim is chosen by the replacement mode selected on an input pin. The modes are least recently used, oldest insertion, and pseudo-random. The least-recently-used mode keeps a generation counter for each set and writes its current value as a stamp on the way that was touched. A core that needs separate instruction and data directories uses one instance of this block for each.

Top module: `cache_dir`

## Requirements
- R1: The number of sets is CACHE_BYTES/(BLOCK_BYTES*WAYS), and all three parameters are powers of two. Address bits [OFF_W-1:0] are the block offset, the next IDX_W bits are the set index, and the remaining upper bits are the tag. The default geometry (8192 bytes, 64-byte blocks, 4 ways) has 32 sets, offset bits [5:0] and index bits [10:6].
- R2: `resp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low at all other times.
- R3: A lookup hits when a valid way in the indexed set holds the address tag. The result is `resp_hit`=1 and `resp_way` = that way. The offset bits have no effect on the result.
- R4: On a miss in a set that still has an empty way, the lowest-numbered empty way is filled and reported on `resp_way` with `resp_hit`=0. This happens whatever the value of `repl_mode`.
- R5: `repl_mode`=0 (least recently used): each lookup stamps the way it hits or fills with the set's generation count and then increments that count. A miss in a full set replaces the way with the smallest stamp.
- R6: `repl_mode`=1 (oldest insertion): a miss in a full set replaces the way that was filled longest ago. Hits do not change this order.
- R7: `repl_mode`=2 or 3 (random): a miss in a full set replaces way (LFSR mod WAYS). The LFSR is 16 bits wide and shifts left every cycle, with bit 0 fed by the XOR of bits 15, 13, 12 and 10. Reset loads 16'hACE1, and the LFSR never holds zero.
- R8: `access_count` increments by one for each lookup and `miss_count` by one for each miss, on the same edge that registers the result. Idle cycles leave both counts unchanged.
- R9: A synchronous active-high `rst` empties every way and clears the generation counts, both counters and `resp_valid`.
- R10: `resp_core` returns the `req_core` value of the lookup it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| repl_mode | input | 2 | Replacement mode: 0 least recently used, 1 oldest insertion, 2/3 random |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Lookup address |
| req_core | input | CORE_W | Requester core identifier |
| resp_valid | output | 1 | Result valid |
| resp_hit | output | 1 | 1 on hit, 0 on miss |
| resp_way | output | WAY_W | Way hit or filled |
| resp_core | output | CORE_W | Core identifier of the answered lookup |
| access_count | output | CNT_W | Lookups since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
The assertions take two things for granted. First, a tag appears at most once in any set, which holds because the block only fills on a miss. Second, the generation count does not wrap, so counters only ever move forward by one. The stimulus keeps within both: every address comes from the block's own miss and fill decisions, and the number of lookups stays far below the range of the generation and statistics counters. The directed sequences fill whole sets and then force evictions under each replacement mode, so that every victim way can be predicted in advance. The bench follows the random mode by running its own copy of the LFSR, built from the polynomial and seed stated in R7.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    typedef enum logic [1:0] {
        REPL_LRU  = 2'd0,
        REPL_FIFO = 2'd1,
        REPL_RND  = 2'd2,
        REPL_RND2 = 2'd3
    } repl_mode_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int unsigned safe_log2(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr
    import cache_dir_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_SEED;
        else     state <= lfsr_step(state);
    end

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) state != 16'd0)
        else $error("LFSR reached zero");
endmodule

// File: rtl/cache_victim.sv
module cache_victim
    import cache_dir_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int GEN_W = 32,
    localparam int WAY_W = safe_log2(WAYS)
)(
    input  repl_mode_e             mode,
    input  logic [WAYS-1:0]        valid_v,
    input  logic [GEN_W-1:0]       use_st [WAYS],
    input  logic [GEN_W-1:0]       ins_st [WAYS],
    input  logic [15:0]            rnd,
    output logic [WAY_W-1:0]       victim
);
    logic             any_free;
    logic [WAY_W-1:0] free_way, lru_way, fifo_way, rnd_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_v[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    always_comb begin
        lru_way  = '0;
        fifo_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (use_st[w] < use_st[lru_way])  lru_way  = WAY_W'(w);
            if (ins_st[w] < ins_st[fifo_way]) fifo_way = WAY_W'(w);
        end
    end

    assign rnd_way = WAY_W'(rnd % 16'(WAYS));

    always_comb begin
        if (any_free) victim = free_way;
        else begin
            unique case (mode)
                REPL_LRU:  victim = lru_way;
                REPL_FIFO: victim = fifo_way;
                default:   victim = rnd_way;
            endcase
        end
    end
endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
    parameter int CNT_W = 32
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_access,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] access_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            access_count <= '0;
            miss_count   <= '0;
        end else begin
            if (inc_access)             access_count <= access_count + 1'b1;
            if (inc_access && inc_miss) miss_count   <= miss_count + 1'b1;
        end
    end

    // R8
    access_step_chk: assert property (@(posedge clk) disable iff (rst)
        inc_access |=> access_count == $past(access_count) + 1'b1)
        else $error("access counter did not step");

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc_access |=> $stable(access_count) && $stable(miss_count))
        else $error("counters moved while idle");

    // R8
    miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
        miss_count <= access_count)
        else $error("misses exceed accesses");
endmodule

// File: rtl/cache_dir.sv
module cache_dir
    import cache_dir_pkg::*;
#(
    parameter int CACHE_BYTES = 8192,
    parameter int BLOCK_BYTES = 64,
    parameter int WAYS        = 4,
    parameter int ADDR_W      = 32,
    parameter int CORE_W      = 2,
    parameter int GEN_W       = 32,
    parameter int CNT_W       = 32,
    localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS),
    localparam int OFF_W = safe_log2(BLOCK_BYTES),
    localparam int IDX_W = safe_log2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W = safe_log2(WAYS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        repl_mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] req_core,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic [CORE_W-1:0] resp_core,
    output logic [CNT_W-1:0]  access_count,
    output logic [CNT_W-1:0]  miss_count
);
    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_t;

    addr_t            a;
    logic [WAYS-1:0]  valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [GEN_W-1:0] use_q   [SETS][WAYS];
    logic [GEN_W-1:0] ins_q   [SETS][WAYS];
    logic [GEN_W-1:0] gen_q   [SETS];

    logic [WAYS-1:0]  match;
    logic             hit;
    logic [WAY_W-1:0] hit_way, victim, sel_way;
    logic [15:0]      rnd;

    assign a = addr_t'(req_addr);

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = valid_q[a.idx][w] && (tag_q[a.idx][w] == a.tag);
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
    assign hit     = |match;
    assign sel_way = hit ? hit_way : victim;

    cache_lfsr u_lfsr (.clk(clk), .rst(rst), .state(rnd));

    cache_victim #(.WAYS(WAYS), .GEN_W(GEN_W)) u_victim (
        .mode    (repl_mode_e'(repl_mode)),
        .valid_v (valid_q[a.idx]),
        .use_st  (use_q[a.idx]),
        .ins_st  (ins_q[a.idx]),
        .rnd     (rnd),
        .victim  (victim)
    );

    cache_stats #(.CNT_W(CNT_W)) u_stats (
        .clk          (clk),
        .rst          (rst),
        .inc_access   (req_valid),
        .inc_miss     (!hit),
        .access_count (access_count),
        .miss_count   (miss_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= '0;
            resp_core  <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                gen_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    use_q[s][w] <= '0;
                    ins_q[s][w] <= '0;
                end
            end
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_hit  <= hit;
                resp_way  <= sel_way;
                resp_core <= req_core;
                gen_q[a.idx]          <= gen_q[a.idx] + 1'b1;
                use_q[a.idx][sel_way] <= gen_q[a.idx];
                if (!hit) begin
                    tag_q[a.idx][sel_way]   <= a.tag;
                    valid_q[a.idx][sel_way] <= 1'b1;
                    ins_q[a.idx][sel_way]   <= gen_q[a.idx];
                end
            end
        end
    end

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match))
        else $error("tag present in more than one way");

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid)
        else $error("missing response");

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid)
        else $error("response without request");

    // R10
    core_echo_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_core == $past(req_core))
        else $error("core id not echoed");
endmodule

// File: tb/tb_cache_dir.sv
module tb_cache_dir;
    import cache_dir_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  repl_mode = 2'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_core = '0;
    logic        resp_valid, resp_hit;
    logic [1:0]  resp_way, resp_core;
    logic [31:0] access_count, miss_count;

    int checks = 0;
    int errors = 0;
    int exp_acc = 0;
    int exp_miss = 0;
    bit done = 1'b0;
    logic [15:0] lfsr_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_dir dut (
        .clk(clk), .rst(rst), .repl_mode(repl_mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_core(req_core),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
        .resp_core(resp_core), .access_count(access_count), .miss_count(miss_count)
    );

    // independent model of the R7 sequence
    always @(posedge clk) begin
        if (rst) lfsr_m <= 16'hACE1;
        else     lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    end

    function automatic logic [31:0] mk(int tag, int set, int off);
        return (32'(tag) << 11) | (32'(set) << 6) | 32'(off);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_acc = 0;
        exp_miss = 0;
    endtask

    task automatic lookup(int tag, int set, int off, int core, bit exp_hit,
                          int exp_way, bit use_rnd, string req);
        int way;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = mk(tag, set, off);
        req_core  = 2'(core);
        way = use_rnd ? int'(lfsr_m % 16'd4) : exp_way;
        @(negedge clk);
        req_valid = 1'b0;
        exp_acc++;
        if (!exp_hit) exp_miss++;
        chk(resp_valid == 1'b1, "R2", int'(resp_valid), 1);
        chk(resp_hit == exp_hit, req, int'(resp_hit), int'(exp_hit));
        chk(resp_way == 2'(way), req, int'(resp_way), way);
        chk(resp_core == 2'(core), "R10", int'(resp_core), core);
        chk(access_count == 32'(exp_acc), "R8 access", int'(access_count), exp_acc);
        chk(miss_count == 32'(exp_miss), "R8 miss", int'(miss_count), exp_miss);
    endtask

    task automatic fill_set(int set, int base);
        for (int w = 0; w < 4; w++) lookup(base + w, set, 0, w, 1'b0, w, 1'b0, "R4 fill");
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(resp_valid == 1'b0, "R9 resp_valid", int'(resp_valid), 0);
        chk(access_count == 0, "R9 access", int'(access_count), 0);
        chk(miss_count == 0, "R9 miss", int'(miss_count), 0);
    endtask

    task automatic t_fill_and_hit();
        repl_mode = 2'd0;
        fill_set(3, 1);
        lookup(2, 3, 0, 1, 1'b1, 1, 1'b0, "R3 hit");
        lookup(4, 3, 37, 2, 1'b1, 3, 1'b0, "R3 offset ignored");
        lookup(2, 4, 0, 0, 1'b0, 0, 1'b0, "R1 index separates sets");
        lookup(2, 4, 63, 3, 1'b1, 0, 1'b0, "R1 offset bits");
    endtask

    task automatic t_lru();
        repl_mode = 2'd0;
        fill_set(5, 10);
        lookup(10, 5, 0, 0, 1'b1, 0, 1'b0, "R5 hit refresh");
        lookup(14, 5, 0, 0, 1'b0, 1, 1'b0, "R5 evict smallest stamp");
        lookup(15, 5, 0, 0, 1'b0, 2, 1'b0, "R5 next victim");
        lookup(14, 5, 0, 0, 1'b1, 1, 1'b0, "R5 new block resident");
        lookup(11, 5, 0, 0, 1'b0, 3, 1'b0, "R5 evicted block misses");
    endtask

    task automatic t_fifo();
        repl_mode = 2'd1;
        fill_set(7, 20);
        lookup(20, 7, 0, 1, 1'b1, 0, 1'b0, "R6 hit");
        lookup(24, 7, 0, 1, 1'b0, 0, 1'b0, "R6 oldest evicted despite hit");
        lookup(25, 7, 0, 1, 1'b0, 1, 1'b0, "R6 next oldest");
        lookup(24, 7, 0, 1, 1'b1, 0, 1'b0, "R6 new block resident");
    endtask

    task automatic t_random();
        repl_mode = 2'd0;
        fill_set(9, 30);
        repl_mode = 2'd2;
        lookup(34, 9, 0, 2, 1'b0, 0, 1'b1, "R7 random victim mode 2");
        repl_mode = 2'd3;
        lookup(35, 9, 0, 3, 1'b0, 0, 1'b1, "R7 random victim mode 3");
    endtask

    task automatic t_idle();
        repeat (3) begin
            @(negedge clk);
            chk(resp_valid == 1'b0, "R2 idle", int'(resp_valid), 0);
            chk(access_count == 32'(exp_acc), "R8 idle", int'(access_count), exp_acc);
        end
    endtask

    task automatic t_reset_clears();
        do_reset();
        t_reset_state();
        repl_mode = 2'd0;
        lookup(2, 3, 0, 0, 1'b0, 0, 1'b0, "R9 valid bits cleared");
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_fill_and_hit();
        t_lru();
        t_fifo();
        t_random();
        t_idle();
        t_reset_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule